// File: doc/BRIEF.md
# Serial Controller Configuration and Register Access Sequencer

This block is the processor-facing control path of a programmable asynchronous serial controller. It turns single-cycle chip-select, write, read and control/data-select strobes into register actions. One control address carries two meanings over time. After reset, the first acceptable control write is taken as the mode word, which sets character length, parity, stop length and clock factor. Every later control write is a command word, until a command with the internal-reset bit set sends the sequencer back to waiting for a mode word.

Reads of the control address return a status byte assembled from the transmitter, the receiver and the modem input. Data-address writes become a load pulse toward the transmit holding register. Data-address reads return the receive buffer byte and pulse a take strobe. The decoded mode and command fields are driven out as configuration for the serial datapaths and the modem handshake lines. Those datapaths and synchronous-mode sync-character loading are not part of this block.

Top module: `usart_ctl_seq`

## Requirements
- R1: After reset, cfg_valid=0, tx_enable=0, rx_enable=0, dtr_n=1, rts_n=1, tx_load=0, rx_take=0 and err_clear=0.
- R2: While waiting (cfg_valid=0), a control write (sel=1, wr_en=1, ctl_sel=1) whose bits [1:0] are not 00 is the mode word. From the next cycle cfg_valid=1 and the fields decode as follows. clk_div is 1, 16 or 64 for [1:0] = 01, 10 or 11. char_bits is 5 plus [3:2]. parity_en is [4]. parity_even is [5] AND [4]. stop_halves is 2, 3 or 4 for [7:6] = 01, 10 or 11, and 2 for 00.
- R3: While waiting, a control write with bits [1:0]=00 (synchronous) is refused. cfg_valid stays 0 and the decoded mode outputs keep their previous values.
- R4: While configured, every control write without bit 6 is a command word and takes effect the next cycle. Bit 0 gives tx_enable, bit 2 gives rx_enable, bit 1 gives dtr_n = NOT bit1, and bit 5 gives rts_n = NOT bit5. Mode outputs stay unchanged, and a command may be rewritten at any time.
- R5: Command bit 4 raises err_clear for exactly the one cycle after the write. The bit is not stored.
- R6: A command with bit 6 set is an internal reset. From the next cycle cfg_valid=0, tx_enable=0, rx_enable=0, dtr_n=1 and rts_n=1, the word's other bits are ignored, and the next control write is treated as a mode word.
- R7: A control read (sel=1, rd_en=1, wr_en=0, ctl_sel=1) loads rdata the next cycle with the status byte. The bits are: 0 tx_hold_empty, 1 rx_full, 2 tx_shift_empty, 3 parity_err, 4 overrun_err, 5 framing_err, 6 constant 0, 7 dsr.
- R8: A data write (ctl_sel=0) while configured raises tx_load for one cycle on the next cycle, with tx_data equal to the written byte. While waiting for a mode word, a data write produces no tx_load.
- R9: A data read (ctl_sel=0) loads rdata with rx_byte on the next cycle and raises rx_take for that one cycle.
- R10: Nothing happens without sel. When wr_en and rd_en are both high, the write is performed and the read is ignored: rdata is held and rx_take stays 0. rdata changes only on an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| ctl_sel | input | 1 | 1 = control/status address, 0 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_shift_empty | input | 1 | Transmit shifter empty |
| rx_full | input | 1 | Receive buffer holds a character |
| parity_err | input | 1 | Receiver parity error flag |
| overrun_err | input | 1 | Receiver overrun error flag |
| framing_err | input | 1 | Receiver framing error flag |
| dsr | input | 1 | Modem data-set-ready, active high |
| rx_byte | input | 8 | Receive buffer contents |
| tx_load | output | 1 | One-cycle load strobe for the transmit holding register |
| tx_data | output | 8 | Byte to load into the transmit holding register |
| rx_take | output | 1 | One-cycle strobe: receive buffer was read |
| err_clear | output | 1 | One-cycle request to clear the error flags |
| cfg_valid | output | 1 | A mode word has been accepted |
| clk_div | output | 7 | Clock factor: 1, 16 or 64 |
| char_bits | output | 4 | Data bits per character, 5 to 8 |
| parity_en | output | 1 | Parity bit generated and checked |
| parity_even | output | 1 | Even parity when parity_en is set |
| stop_halves | output | 3 | Stop length in half-bit periods |
| tx_enable | output | 1 | Transmitter enabled |
| rx_enable | output | 1 | Receiver enabled |
| dtr_n | output | 1 | Terminal-ready line, active low |
| rts_n | output | 1 | Request-to-send line, active low |

## Verification
Every result of an access lands exactly one clock after the edge that samples the strobe. This covers mode fields, command outputs, rdata, and the tx_load, rx_take and err_clear pulses. The one-cycle pulses fall again one clock later. The bench drives each access on a falling edge for one cycle and checks at the next falling edge, half a period after the capturing edge. For every pulse it then checks again one full cycle later that the pulse is gone. Refused or ignored accesses are checked in the same cycle slot, on the outputs they would otherwise have changed.

// File: rtl/usart_ctl_pkg.sv
package usart_ctl_pkg;

  typedef enum logic {
    ST_WAIT_MODE = 1'b0,
    ST_RUN       = 1'b1
  } seq_state_t;

  // Mode word field positions (bit 7 first)
  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       par_en;
    logic [1:0] len;
    logic [1:0] factor;
  } mode_t;

  // Stored command controls
  typedef struct packed {
    logic rts;
    logic dtr;
    logic rxen;
    logic txen;
  } ctl_t;

  typedef struct packed {
    logic wr_ctl;
    logic rd_ctl;
    logic wr_dat;
    logic rd_dat;
  } acc_t;

  localparam int CMD_TXEN = 0;
  localparam int CMD_DTR  = 1;
  localparam int CMD_RXEN = 2;
  localparam int CMD_ECLR = 4;
  localparam int CMD_RTS  = 5;
  localparam int CMD_IRST = 6;

  function automatic logic [6:0] factor_to_div(input logic [1:0] f);
    case (f)
      2'b01:   factor_to_div = 7'd1;
      2'b10:   factor_to_div = 7'd16;
      2'b11:   factor_to_div = 7'd64;
      default: factor_to_div = 7'd0;
    endcase
  endfunction

  function automatic logic [2:0] stop_to_halves(input logic [1:0] s);
    case (s)
      2'b10:   stop_to_halves = 3'd3;
      2'b11:   stop_to_halves = 3'd4;
      default: stop_to_halves = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/usart_bus_decode.sv
module usart_bus_decode
  import usart_ctl_pkg::*;
(
  input  logic sel,
  input  logic wr_en,
  input  logic rd_en,
  input  logic ctl_sel,
  output acc_t acc
);

  logic wr_hit;
  logic rd_hit;

  // A write takes priority; a read coinciding with a write is dropped
  assign wr_hit = sel & wr_en;
  assign rd_hit = sel & rd_en & ~wr_en;

  always_comb begin
    acc        = '0;
    acc.wr_ctl = wr_hit & ctl_sel;
    acc.wr_dat = wr_hit & ~ctl_sel;
    acc.rd_ctl = rd_hit & ctl_sel;
    acc.rd_dat = rd_hit & ~ctl_sel;
  end

endmodule

// File: rtl/usart_cfg_fsm.sv
module usart_cfg_fsm
  import usart_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  output seq_state_t    state,
  output mode_t         mode,
  output ctl_t          ctl,
  output logic          eclr_pulse
);

  localparam int MW = $bits(mode_t);

  seq_state_t st_q, st_d;
  mode_t      mode_q, mode_d;
  ctl_t       ctl_q, ctl_d;
  logic       eclr_q, eclr_d;
  logic       mode_en, ctl_en;
  logic       mode_ok;

  assign mode_ok = (wdata[1:0] != 2'b00);

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    ctl_d   = ctl_q;
    eclr_d  = 1'b0;
    mode_en = 1'b0;
    ctl_en  = 1'b0;
    if (wr_ctl) begin
      if (st_q == ST_WAIT_MODE) begin
        if (mode_ok) begin
          mode_d  = mode_t'(wdata[MW-1:0]);
          mode_en = 1'b1;
          st_d    = ST_RUN;
        end
      end else if (wdata[CMD_IRST]) begin
        st_d   = ST_WAIT_MODE;
        ctl_d  = '0;
        ctl_en = 1'b1;
      end else begin
        ctl_d.txen = wdata[CMD_TXEN];
        ctl_d.dtr  = wdata[CMD_DTR];
        ctl_d.rxen = wdata[CMD_RXEN];
        ctl_d.rts  = wdata[CMD_RTS];
        ctl_en     = 1'b1;
        eclr_d     = wdata[CMD_ECLR];
      end
    end
  end

  // State and configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAIT_MODE;
      mode_q <= '0;
      ctl_q  <= '0;
      eclr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      eclr_q <= eclr_d;
      if (mode_en) mode_q <= mode_d;
      if (ctl_en)  ctl_q  <= ctl_d;
    end
  end

  assign state      = st_q;
  assign mode       = mode_q;
  assign ctl        = ctl_q;
  assign eclr_pulse = eclr_q;

endmodule

// File: rtl/usart_rd_port.sv
module usart_rd_port
  import usart_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_t          acc,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] rdata,
  output logic          rx_take
);

  logic [DW-1:0] rd_q, rd_d;
  logic          rd_en_q;
  logic          take_q;

  assign rd_en_q = acc.rd_ctl | acc.rd_dat;

  always_comb begin
    rd_d = rd_q;
    if (acc.rd_ctl)      rd_d = status;
    else if (acc.rd_dat) rd_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      take_q <= 1'b0;
    end else begin
      take_q <= acc.rd_dat;
      if (rd_en_q) rd_q <= rd_d;
    end
  end

  assign rdata   = rd_q;
  assign rx_take = take_q;

endmodule

// File: rtl/usart_tx_port.sv
module usart_tx_port
  import usart_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_dat,
  input  logic          configured,
  input  logic [DW-1:0] wdata,
  output logic          tx_load,
  output logic [DW-1:0] tx_data
);

  logic          ld_d, ld_q;
  logic [DW-1:0] dat_q;

  assign ld_d = wr_dat & configured;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      ld_q <= ld_d;
      if (ld_d) dat_q <= wdata;
    end
  end

  assign tx_load = ld_q;
  assign tx_data = dat_q;

endmodule

// File: rtl/usart_ctl_seq.sv
module usart_ctl_seq
  import usart_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          ctl_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tx_hold_empty,
  input  logic          tx_shift_empty,
  input  logic          rx_full,
  input  logic          parity_err,
  input  logic          overrun_err,
  input  logic          framing_err,
  input  logic          dsr,
  input  logic [DW-1:0] rx_byte,
  output logic          tx_load,
  output logic [DW-1:0] tx_data,
  output logic          rx_take,
  output logic          err_clear,
  output logic          cfg_valid,
  output logic [6:0]    clk_div,
  output logic [3:0]    char_bits,
  output logic          parity_en,
  output logic          parity_even,
  output logic [2:0]    stop_halves,
  output logic          tx_enable,
  output logic          rx_enable,
  output logic          dtr_n,
  output logic          rts_n
);

  localparam int SW = 8;

  acc_t          acc;
  seq_state_t    state;
  mode_t         mode;
  ctl_t          ctl;
  logic [SW-1:0] stat8;
  logic [DW-1:0] status;

  usart_bus_decode u_dec (
    .sel     (sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .ctl_sel (ctl_sel),
    .acc     (acc)
  );

  usart_cfg_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (acc.wr_ctl),
    .wdata      (wdata),
    .state      (state),
    .mode       (mode),
    .ctl        (ctl),
    .eclr_pulse (err_clear)
  );

  assign cfg_valid = (state == ST_RUN);

  // Status byte assembly; upper bits padded when DW exceeds 8
  assign stat8 = {dsr, 1'b0, framing_err, overrun_err, parity_err,
                  tx_shift_empty, rx_full, tx_hold_empty};

  generate
    if (DW > SW) begin : g_wide
      assign status = {{(DW-SW){1'b0}}, stat8};
    end else begin : g_narrow
      assign status = stat8[DW-1:0];
    end
  endgenerate

  usart_rd_port #(.DW(DW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (acc),
    .status  (status),
    .rx_byte (rx_byte),
    .rdata   (rdata),
    .rx_take (rx_take)
  );

  usart_tx_port #(.DW(DW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_dat     (acc.wr_dat),
    .configured (cfg_valid),
    .wdata      (wdata),
    .tx_load    (tx_load),
    .tx_data    (tx_data)
  );

  // Field decode toward the serial datapaths
  assign clk_div     = factor_to_div(mode.factor);
  assign char_bits   = 4'd5 + {2'b00, mode.len};
  assign parity_en   = mode.par_en;
  assign parity_even = mode.par_en & mode.even;
  assign stop_halves = stop_to_halves(mode.stop);

  assign tx_enable = ctl.txen;
  assign rx_enable = ctl.rxen;
  assign dtr_n     = ~ctl.dtr;
  assign rts_n     = ~ctl.rts;

endmodule

// File: rtl/usart_ctl_seq_chk.sv
module usart_ctl_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ctl_sel,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] rx_byte,
  input logic          tx_load,
  input logic [DW-1:0] tx_data,
  input logic          rx_take,
  input logic          err_clear,
  input logic          cfg_valid,
  input logic [3:0]    char_bits,
  input logic          tx_enable,
  input logic          dtr_n,
  input logic          rts_n
);

  logic wctl, wdat, rdat;
  assign wctl = sel && wr_en && ctl_sel;
  assign wdat = sel && wr_en && !ctl_sel;
  assign rdat = sel && rd_en && !wr_en && !ctl_sel;

  // R2
  mode_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wctl && !cfg_valid && wdata[1:0] != 2'b00) |=> cfg_valid);

  // R3
  sync_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wctl && !cfg_valid && wdata[1:0] == 2'b00) |=> (!cfg_valid && $stable(char_bits)));

  // R4
  cmd_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wctl && cfg_valid && !wdata[6]) |=>
      (cfg_valid && tx_enable == $past(wdata[0]) && dtr_n == !$past(wdata[1])
       && rts_n == !$past(wdata[5]) && $stable(char_bits)));

  // R5
  eclr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wctl && cfg_valid && !wdata[6] && wdata[4]) |=> err_clear);

  // R5
  eclr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wctl && cfg_valid && !wdata[6] && wdata[4]) |=> !err_clear);

  // R6
  int_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wctl && cfg_valid && wdata[6]) |=> (!cfg_valid && !tx_enable && dtr_n && rts_n));

  // R8
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat && cfg_valid) |=> (tx_load && tx_data == $past(wdata)));

  // R8
  tx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdat && !cfg_valid) |=> !tx_load);

  // R9
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdat |=> (rx_take && rdata == $past(rx_byte)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && rd_en && !wr_en) |=> ($stable(rdata) && !rx_take));

endmodule

bind usart_ctl_seq usart_ctl_seq_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .ctl_sel   (ctl_sel),
  .wdata     (wdata),
  .rdata     (rdata),
  .rx_byte   (rx_byte),
  .tx_load   (tx_load),
  .tx_data   (tx_data),
  .rx_take   (rx_take),
  .err_clear (err_clear),
  .cfg_valid (cfg_valid),
  .char_bits (char_bits),
  .tx_enable (tx_enable),
  .dtr_n     (dtr_n),
  .rts_n     (rts_n)
);

// File: tb/sim_usart_ctl_seq.sv
module sim_usart_ctl_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ctl_sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_hold_empty = 1'b0, tx_shift_empty = 1'b0, rx_full = 1'b0;
  logic       parity_err = 1'b0, overrun_err = 1'b0, framing_err = 1'b0, dsr = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_load, rx_take, err_clear, cfg_valid;
  logic [7:0] tx_data;
  logic [6:0] clk_div;
  logic [3:0] char_bits;
  logic       parity_en, parity_even;
  logic [2:0] stop_halves;
  logic       tx_enable, rx_enable, dtr_n, rts_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  usart_ctl_seq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One-cycle access; returns at the falling edge after the capturing edge
  task automatic access(input logic s, input logic w, input logic r,
                        input logic c, input logic [7:0] d);
    @(negedge clk);
    sel = s; wr_en = w; rd_en = r; ctl_sel = c; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ctl_sel = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cfg_valid", cfg_valid, 0);
    chk("R1 tx_enable", tx_enable, 0);
    chk("R1 rx_enable", rx_enable, 0);
    chk("R1 dtr_n", dtr_n, 1);
    chk("R1 rts_n", rts_n, 1);
    chk("R1 pulses", {tx_load, rx_take, err_clear}, 0);
  endtask

  task automatic t_data_before_mode;
    access(1, 1, 0, 0, 8'h5A);
    chk("R8 no load while waiting", tx_load, 0);
  endtask

  task automatic t_sync_refuse;
    access(1, 1, 0, 1, 8'hC8);
    chk("R3 refused cfg_valid", cfg_valid, 0);
    chk("R3 clk_div unchanged", clk_div, 0);
  endtask

  task automatic t_mode_ca;
    access(1, 1, 0, 1, 8'hCA);
    chk("R2 cfg_valid", cfg_valid, 1);
    chk("R2 char_bits", char_bits, 7);
    chk("R2 parity_en", parity_en, 0);
    chk("R2 stop_halves", stop_halves, 4);
    chk("R2 clk_div", clk_div, 16);
  endtask

  task automatic t_commands;
    access(1, 1, 0, 1, 8'h11);
    chk("R4 tx_enable", tx_enable, 1);
    chk("R4 rx_enable", rx_enable, 0);
    chk("R4 dtr_n/rts_n", {dtr_n, rts_n}, 2'b11);
    chk("R4 mode kept", char_bits, 7);
    chk("R5 err_clear pulse", err_clear, 1);
    @(negedge clk);
    chk("R5 err_clear falls", err_clear, 0);
    access(1, 1, 0, 1, 8'h26);
    chk("R4 rewrite tx/rx", {tx_enable, rx_enable}, 2'b01);
    chk("R4 rewrite dtr_n/rts_n", {dtr_n, rts_n}, 2'b00);
    chk("R5 no err_clear", err_clear, 0);
    chk("R4 still configured", cfg_valid, 1);
  endtask

  task automatic t_status;
    tx_hold_empty = 1; rx_full = 0; tx_shift_empty = 1;
    parity_err = 0; overrun_err = 1; framing_err = 0; dsr = 1;
    access(1, 0, 1, 1, 8'h00);
    chk("R7 status pattern A", rdata, 8'h95);
    tx_hold_empty = 0; rx_full = 1; tx_shift_empty = 0;
    parity_err = 1; overrun_err = 0; framing_err = 1; dsr = 0;
    access(1, 0, 1, 1, 8'h00);
    chk("R7 status pattern B", rdata, 8'h2A);
    chk("R7 no rx_take", rx_take, 0);
  endtask

  task automatic t_tx_data;
    access(1, 1, 0, 0, 8'hA5);
    chk("R8 tx_load", tx_load, 1);
    chk("R8 tx_data", tx_data, 8'hA5);
    @(negedge clk);
    chk("R8 tx_load falls", tx_load, 0);
  endtask

  task automatic t_rx_read;
    rx_byte = 8'h3C;
    access(1, 0, 1, 0, 8'h00);
    chk("R9 rdata", rdata, 8'h3C);
    chk("R9 rx_take", rx_take, 1);
    @(negedge clk);
    chk("R9 rx_take falls", rx_take, 0);
  endtask

  task automatic t_no_sel_and_priority;
    rx_byte = 8'hE7;
    access(0, 1, 0, 0, 8'h11);
    chk("R10 no sel no load", tx_load, 0);
    access(0, 0, 1, 0, 8'h00);
    chk("R10 no sel rdata held", rdata, 8'h3C);
    chk("R10 no sel no take", rx_take, 0);
    access(1, 1, 1, 0, 8'h77);
    chk("R10 write wins load", tx_load, 1);
    chk("R10 write wins data", tx_data, 8'h77);
    chk("R10 read dropped take", rx_take, 0);
    chk("R10 read dropped rdata", rdata, 8'h3C);
  endtask

  task automatic t_internal_reset;
    access(1, 1, 0, 1, 8'h67);
    chk("R6 cfg_valid cleared", cfg_valid, 0);
    chk("R6 enables cleared", {tx_enable, rx_enable}, 0);
    chk("R6 lines idle", {dtr_n, rts_n}, 2'b11);
    chk("R6 other bits ignored", err_clear, 0);
    access(1, 1, 0, 1, 8'h4C);
    chk("R3 refused after reset", cfg_valid, 0);
    chk("R3 fields kept", char_bits, 7);
    access(1, 1, 0, 1, 8'h7F);
    chk("R6 next write is mode", cfg_valid, 1);
    chk("R2 char_bits 8", char_bits, 8);
    chk("R2 parity", {parity_en, parity_even}, 2'b11);
    chk("R2 stop 1", stop_halves, 2);
    chk("R2 clk_div 64", clk_div, 64);
    chk("R6 command still clear", tx_enable, 0);
    access(1, 1, 0, 1, 8'h40);
    access(1, 1, 0, 1, 8'h8D);
    chk("R2 stop 1.5", stop_halves, 3);
    chk("R2 clk_div 1", clk_div, 1);
    chk("R2 parity off", {parity_en, parity_even}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_data_before_mode;
    t_sync_refuse;
    t_mode_ca;
    t_commands;
    t_status;
    t_tx_data;
    t_rx_read;
    t_no_sel_and_priority;
    t_internal_reset;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule